// File: doc/BRIEF.md
# Prescaled watchdog timer

The block is a bus-attached watchdog. A two-stage clock chain turns the bus clock into a slow tick. The first stage is an 8-bit programmable prescaler that divides by P+1. The second stage is a power-of-two divider that divides by 16, 32, 64 or 128. Each tick decrements a 16-bit down-counter. When the counter runs out, it reloads from a reload register. Depending on two independent enable bits, it also latches an interrupt flag, pulses a reset request, or does both.

Software arms the timer by writing the reload value, the starting count and the control word. It keeps the system alive by rewriting the live count before expiry. It acknowledges an interrupt by writing a one to a dedicated clear register. Clearing the run bit freezes the counter, resets the tick chain and silences the reset request.

Top module: `tick_watchdog`

## Requirements
- R1: After reset, the control register reads 0 and both the reload and live count registers read 0x8000. The irq_o and rst_req_o outputs are low, and a read of the clear register at 0x0C returns 0.
- R2: The control register is at 0x00. Bit 0 is reset enable, bit 2 is interrupt enable, bits 4:3 are the divider select, bit 5 is run and bits 15:8 are the prescale value P. A read returns exactly these fields, and every other bit reads 0.
- R3: While run is 0, no tick occurs and the counter holds its value, so neither irq_o nor rst_req_o can be raised. This holds even with both enable bits set.
- R4: With run set, a tick occurs every (P+1)×D bus clocks, where D is 16 << select. The first tick occurs exactly (P+1)×D clocks after the edge that writes run=1, and each tick lowers the count by one.
- R5: A write to 0x08 loads the live counter at that clock edge, whether run is set or not. If a tick falls in the same cycle as this write, the write wins: no decrement and no expiry take place.
- R6: A tick that finds the count at 1 or 0 is an expiry, and the counter reloads from the reload register. A start count of N≥1 therefore expires N×(P+1)×D clocks after run is set, and a count of 0 expires on the first tick.
- R7: On an expiry with interrupt enable set, irq_o rises and stays high until a write to 0x0C with data bit 0 set. A write to 0x0C with bit 0 clear has no effect. An expiry in the same cycle as a clear leaves irq_o high.
- R8: On an expiry with reset enable set, rst_req_o goes high for one tick period, until the next tick. It drops one clock after run or reset enable is cleared.
- R9: The two enables act independently. An expiry with only interrupt enable set leaves rst_req_o low, and an expiry with only reset enable set leaves irq_o low.
- R10: The reload register at 0x04 holds 16 bits. Write data bits 31:16 are dropped, and those bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, also the timer's count source |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq_o | output | 1 | Latched expiry interrupt |
| rst_req_o | output | 1 | Expiry reset request, one tick long |

## Verification
Two collisions can occur in one cycle. A keep-alive write to the count register can land on the clock edge where a tick would expire the counter. An interrupt-clear write can land on the edge where a fresh expiry sets the flag. The bench provokes both by counting clock edges from the write that sets run, so that the bus write hits exactly the tick edge. For the keep-alive collision, the written value must stand undecremented with both outputs still low. For the clear collision, irq_o must remain high, because setting the flag takes priority.

// File: rtl/twd_pkg.sv
// Package: shared control-word layout and register offsets of the watchdog.
// Assumes byte addressing with 32-bit registers on word-aligned offsets.
package twd_pkg;

    localparam int TWD_PRE_W = 8;   // prescale field width
    localparam int TWD_SEL_W = 2;   // divider select width

    // Register byte offsets
    localparam int OFS_CTRL = 'h0;
    localparam int OFS_RLD  = 'h4;
    localparam int OFS_CNT  = 'h8;
    localparam int OFS_CLR  = 'hC;

    // Control word bit positions
    localparam int BIT_REN  = 0;
    localparam int BIT_IEN  = 2;
    localparam int DSEL_LSB = 3;
    localparam int BIT_RUN  = 5;
    localparam int PRE_LSB  = 8;

    typedef struct packed {
        logic [TWD_PRE_W-1:0] pre;
        logic [TWD_SEL_W-1:0] dsel;
        logic                 run;
        logic                 ien;
        logic                 ren;
    } twd_ctrl_t;

endpackage

// File: rtl/twd_regs.sv
// Register file and decode for the watchdog.
// Holds control and reload, and turns bus writes into a count-load strobe and
// an interrupt-clear strobe. Reads are combinational. Assumes DATA_W >= 16.
module twd_regs
    import twd_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 16,
    parameter int RLD_RST = 'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cnt_live,
    output twd_ctrl_t         ctrl,
    output logic [CNT_W-1:0]  reload,
    output logic              cnt_ld,
    output logic [CNT_W-1:0]  cnt_ld_val,
    output logic              irq_clr,
    output logic [DATA_W-1:0] bus_rdata
);

    logic hit_ctrl, hit_rld, hit_cnt, hit_clr;
    logic unused_wdata;

    assign unused_wdata = ^bus_wdata;

    // Address decode per register
    assign hit_ctrl = bus_sel && (bus_addr == ADDR_W'(OFS_CTRL));
    assign hit_rld  = bus_sel && (bus_addr == ADDR_W'(OFS_RLD));
    assign hit_cnt  = bus_sel && (bus_addr == ADDR_W'(OFS_CNT));
    assign hit_clr  = bus_sel && (bus_addr == ADDR_W'(OFS_CLR));

    // Strobes toward the counter and event logic
    assign cnt_ld     = hit_cnt && bus_wr;
    assign cnt_ld_val = bus_wdata[CNT_W-1:0];
    assign irq_clr    = hit_clr && bus_wr && bus_wdata[0];

    // Control register storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (hit_ctrl && bus_wr) begin
            ctrl.pre  <= bus_wdata[PRE_LSB +: TWD_PRE_W];
            ctrl.dsel <= bus_wdata[DSEL_LSB +: TWD_SEL_W];
            ctrl.run  <= bus_wdata[BIT_RUN];
            ctrl.ien  <= bus_wdata[BIT_IEN];
            ctrl.ren  <= bus_wdata[BIT_REN];
        end
    end

    // Reload register storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload <= CNT_W'(RLD_RST);
        end else if (hit_rld && bus_wr) begin
            reload <= bus_wdata[CNT_W-1:0];
        end
    end

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (!bus_wr) begin
            if (hit_ctrl) begin
                bus_rdata[PRE_LSB +: TWD_PRE_W]  = ctrl.pre;
                bus_rdata[DSEL_LSB +: TWD_SEL_W] = ctrl.dsel;
                bus_rdata[BIT_RUN]               = ctrl.run;
                bus_rdata[BIT_IEN]               = ctrl.ien;
                bus_rdata[BIT_REN]               = ctrl.ren;
            end else if (hit_rld) begin
                bus_rdata[CNT_W-1:0] = reload;
            end else if (hit_cnt) begin
                bus_rdata[CNT_W-1:0] = cnt_live;
            end
        end
    end

endmodule

// File: rtl/twd_tickgen.sv
// Tick generator: a prescaler dividing by pre+1, then a power-of-two divider
// picking 2**(BASE_LOG+dsel). Both stages are held at zero while run is low,
// so the first tick comes one full period after run rises. Assumes BASE_LOG >= 1.
module twd_tickgen #(
    parameter int PRE_W    = 8,
    parameter int SEL_W    = 2,
    parameter int BASE_LOG = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] pre,
    input  logic [SEL_W-1:0] dsel,
    output logic             tick
);

    localparam int NSEL  = 1 << SEL_W;
    localparam int DIV_W = BASE_LOG + NSEL - 1;

    logic [PRE_W-1:0] pre_q;
    logic [DIV_W-1:0] div_q;
    logic             pre_done;
    logic [NSEL-1:0]  term_vec;

    assign pre_done = run && (pre_q == pre);

    // Prescale stage: counts 0..pre, cleared while stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_q <= '0;
        end else if (pre_done) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // Divider stage: free binary count of prescaler periods, cleared while stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_q <= '0;
        end else if (pre_done) begin
            div_q <= div_q + 1'b1;
        end
    end

    // One terminal detector per divider setting: low bits all ones
    for (genvar s = 0; s < NSEL; s++) begin : g_term
        assign term_vec[s] = &div_q[BASE_LOG+s-1:0];
    end

    assign tick = pre_done && term_vec[dsel];

endmodule

// File: rtl/twd_counter.sv
// Watchdog down-counter. A bus load takes priority over a tick. A tick that
// finds the count at 1 or 0 is an expiry and reloads; otherwise it decrements.
module twd_counter #(
    parameter int CNT_W   = 16,
    parameter int CNT_RST = 'h8000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

    assign expire = tick && !ld && (cnt_q <= LAST);

    // Count state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(CNT_RST);
        end else if (ld) begin
            cnt_q <= ld_val;
        end else if (expire) begin
            cnt_q <= reload;
        end else if (tick) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/twd_events.sv
// Expiry outputs. A sticky interrupt flag is set by expiry, where set beats
// clear. A reset request lasts from an expiry tick to the next tick and is
// forced low whenever run or reset enable is low.
module twd_events (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ien,
    input  logic ren,
    input  logic tick,
    input  logic expire,
    input  logic irq_clr,
    output logic irq_o,
    output logic rst_o
);

    // Interrupt latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else if (expire && ien) begin
            irq_o <= 1'b1;
        end else if (irq_clr) begin
            irq_o <= 1'b0;
        end
    end

    // Reset request, re-evaluated on every tick
    always_ff @(posedge clk) begin
        if (!rst_n || !run || !ren) begin
            rst_o <= 1'b0;
        end else if (tick) begin
            rst_o <= expire;
        end
    end

endmodule

// File: rtl/tick_watchdog.sv
// Top of the prescaled watchdog: register file, tick chain, down-counter and
// expiry outputs. Single clock domain; synchronous active-low reset.
module tick_watchdog
    import twd_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 16,
    parameter int BASE_LOG = 4,
    parameter int CNT_RST  = 'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              rst_req_o
);

    twd_ctrl_t        ctrl_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] ld_val;
    logic             cnt_ld;
    logic             irq_clr;
    logic             tick;
    logic             expire;

    twd_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .RLD_RST(CNT_RST)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt_live  (cnt_q),
        .ctrl      (ctrl_q),
        .reload    (reload_q),
        .cnt_ld    (cnt_ld),
        .cnt_ld_val(ld_val),
        .irq_clr   (irq_clr),
        .bus_rdata (bus_rdata)
    );

    twd_tickgen #(
        .PRE_W   (TWD_PRE_W),
        .SEL_W   (TWD_SEL_W),
        .BASE_LOG(BASE_LOG)
    ) tick_i (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (ctrl_q.run),
        .pre  (ctrl_q.pre),
        .dsel (ctrl_q.dsel),
        .tick (tick)
    );

    twd_counter #(
        .CNT_W  (CNT_W),
        .CNT_RST(CNT_RST)
    ) cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .ld    (cnt_ld),
        .ld_val(ld_val),
        .reload(reload_q),
        .cnt_q (cnt_q),
        .expire(expire)
    );

    twd_events evt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (ctrl_q.run),
        .ien    (ctrl_q.ien),
        .ren    (ctrl_q.ren),
        .tick   (tick),
        .expire (expire),
        .irq_clr(irq_clr),
        .irq_o  (irq_o),
        .rst_o  (rst_req_o)
    );

endmodule

// File: rtl/tick_watchdog_chk.sv
// Property checker for tick_watchdog, attached by bind below. It observes the
// control fields, tick, load strobe, counter and outputs.
module tick_watchdog_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_wr,
    input logic             run,
    input logic             ien,
    input logic             ren,
    input logic             tick,
    input logic             ld,
    input logic [CNT_W-1:0] ld_val,
    input logic [CNT_W-1:0] reload,
    input logic [CNT_W-1:0] cnt,
    input logic             expire,
    input logic             irq,
    input logic             rst_req
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

    p_stopped_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick);

    p_stopped_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ld) |=> $stable(cnt));

    p_decrement_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld && cnt > LAST) |=> (cnt == $past(cnt) - 1'b1));

    p_load_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (cnt == $past(ld_val)));

    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld && cnt <= LAST) |=> (cnt == $past(reload)));

    p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_wr) |=> irq);

    p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(expire && ien));

    p_rst_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run || !ren) |=> !rst_req);

    p_rst_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(expire));

endmodule

bind tick_watchdog tick_watchdog_chk #(.CNT_W(CNT_W)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_wr (bus_sel && bus_wr && (bus_addr == ADDR_W'(twd_pkg::OFS_CLR)) && bus_wdata[0]),
    .run    (ctrl_q.run),
    .ien    (ctrl_q.ien),
    .ren    (ctrl_q.ren),
    .tick   (tick),
    .ld     (cnt_ld),
    .ld_val (ld_val),
    .reload (reload_q),
    .cnt    (cnt_q),
    .expire (expire),
    .irq    (irq_o),
    .rst_req(rst_req_o)
);

// File: tb/tick_watchdog_tb_top.sv
// Directed bench for tick_watchdog. Inputs change and outputs are sampled on
// the falling edge. E0 is the rising edge that writes run=1.
module tick_watchdog_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel;
    logic        bus_wr;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        rst_req_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    tick_watchdog dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq_o    (irq_o),
        .rst_req_o(rst_req_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic chk_cnt(input string req, input logic [31:0] exp);
        logic [31:0] v;
        rd(4'h8, v);
        chk(req, "count", v, exp);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(4'h0, v); chk("R1", "ctrl", v, 32'h0);
        rd(4'h4, v); chk("R1", "reload", v, 32'h8000);
        chk_cnt("R1", 32'h8000);
        rd(4'hC, v); chk("R1", "clear read", v, 32'h0);
        chk("R1", "irq", irq_o, 0);
        chk("R1", "rst", rst_req_o, 0);
    endtask

    task automatic t_fields();
        logic [31:0] v;
        wr(4'h0, 32'hFFFF_A5DF);
        rd(4'h0, v); chk("R2", "ctrl fields", v, 32'h0000_A51D);
        wr(4'h4, 32'hFFFF_1234);
        rd(4'h4, v); chk("R10", "reload width", v, 32'h1234);
        wr(4'h0, 32'h0);
    endtask

    task automatic t_stopped();
        wr(4'h0, 32'h1D);
        wr(4'h8, 32'h3);
        chk_cnt("R5", 32'h3);
        idle(300);
        chk_cnt("R3", 32'h3);
        chk("R3", "irq while stopped", irq_o, 0);
        chk("R3", "rst while stopped", rst_req_o, 0);
        wr(4'h0, 32'h0);
    endtask

    task automatic t_rate();
        logic [31:0] a, b;
        wr(4'h4, 32'd100);
        wr(4'h8, 32'd10);
        wr(4'h0, 32'h228);          // P=2, divide by 32, run: period 96
        idle(95);  chk_cnt("R4", 32'd10);
        idle(1);   chk_cnt("R4", 32'd9);
        idle(96);  chk_cnt("R4", 32'd8);
        wr(4'h0, 32'h0);
        rd(4'h8, a);
        idle(200);
        rd(4'h8, b);
        chk("R3", "hold after stop", b, a);
        chk("R3", "value at stop", a, 32'd8);
    endtask

    task automatic t_irq();
        wr(4'hC, 32'h1);
        wr(4'h4, 32'd4);
        wr(4'h8, 32'd2);
        wr(4'h0, 32'h24);           // run + irq enable, P=0, divide by 16
        idle(31);
        chk_cnt("R6", 32'd1);
        chk("R6", "irq before expiry", irq_o, 0);
        idle(1);
        chk("R7", "irq at expiry", irq_o, 1);
        chk_cnt("R6", 32'd4);
        chk("R9", "rst with only irq enabled", rst_req_o, 0);
        wr(4'hC, 32'h0);            // edge E0+33
        chk("R7", "clear with bit0=0", irq_o, 1);
        wr(4'hC, 32'h1);            // edge E0+34
        chk("R7", "clear with bit0=1", irq_o, 0);
        idle(61);
        wr(4'hC, 32'h1);            // edge E0+96 coincides with next expiry
        chk("R7", "set beats clear", irq_o, 1);
        wr(4'hC, 32'h1);
        chk("R7", "clear after collision", irq_o, 0);
        wr(4'h0, 32'h0);
    endtask

    task automatic t_pulse();
        wr(4'hC, 32'h1);
        wr(4'h4, 32'd2);
        wr(4'h8, 32'd1);
        wr(4'h0, 32'h21);           // run + reset enable, period 16
        idle(15); chk("R8", "rst before expiry", rst_req_o, 0);
        idle(1);  chk("R8", "rst at expiry", rst_req_o, 1);
        chk("R9", "irq with only reset enabled", irq_o, 0);
        idle(15); chk("R8", "rst held for tick", rst_req_o, 1);
        idle(1);  chk("R8", "rst ends at next tick", rst_req_o, 0);
        chk_cnt("R4", 32'd1);
        idle(16); chk("R8", "rst second expiry", rst_req_o, 1);
        wr(4'h0, 32'h0);
        idle(1);  chk("R8", "rst dropped by stop", rst_req_o, 0);
    endtask

    task automatic t_keepalive();
        wr(4'hC, 32'h1);
        wr(4'h4, 32'd5);
        wr(4'h8, 32'd1);
        wr(4'h0, 32'h25);
        idle(15);
        wr(4'h8, 32'h30);           // edge E0+16 coincides with expiring tick
        chk_cnt("R5", 32'h30);
        chk("R5", "no irq on collision", irq_o, 0);
        chk("R5", "no rst on collision", rst_req_o, 0);
        idle(16);
        chk_cnt("R5", 32'h2F);
        wr(4'h0, 32'h0);
    endtask

    task automatic t_zero();
        wr(4'hC, 32'h1);
        wr(4'h8, 32'd0);
        wr(4'h4, 32'd7);
        wr(4'h0, 32'h13C);          // P=1, divide by 128, run + irq: period 256
        idle(255);
        chk("R6", "zero count before tick", irq_o, 0);
        idle(1);
        chk("R6", "zero count expires", irq_o, 1);
        chk_cnt("R6", 32'd7);
        wr(4'h0, 32'h0);
        wr(4'hC, 32'h1);
    endtask

    task automatic t_maxdiv();
        wr(4'h4, 32'd9);
        wr(4'h8, 32'd1);
        wr(4'h0, 32'hFF39);         // P=255, divide by 128, run + reset: 32768
        idle(32767);
        chk("R4", "rst before longest period", rst_req_o, 0);
        chk_cnt("R4", 32'd1);
        idle(1);
        chk("R4", "rst at longest period", rst_req_o, 1);
        chk_cnt("R6", 32'd9);
        wr(4'h0, 32'h0);
    endtask

    initial begin
        rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        idle(4);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_fields();
        t_stopped();
        t_rate();
        t_irq();
        t_pulse();
        t_keepalive();
        t_zero();
        t_maxdiv();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule